// File: doc/BRIEF.md
# Hashed Page Table Index Hash

This block turns a translation request into the index used to pick an entry group in a hashed page table. A request carries an effective address, the segment's virtual segment identifier (VSID), a one-bit segment size selector and the base-2 logarithm of the page size. The first pipeline stage builds the virtual page number (VPN), which is the virtual address with its low 12 bits dropped. The second stage folds that VPN into a 39-bit primary hash. It also produces the secondary hash and flags a page shift that cannot be valid.

The two segment sizes use different folds. For small 256 MB segments, the bits above the in-segment page index are XORed with the page index. The page index is first shifted right to remove the base-page bits. For large 1 TB segments, the segment identifier taken from the VPN is also XORed with a copy of itself shifted left by 25 before the same page-index term is added. A downstream group search uses the primary hash, or its complement as the secondary hash, together with a table mask. One request is accepted on any cycle.

Top module: `hpt_index_hash`

## Requirements
- R1: With `in_seg_1t` = 0 (256 MB segment), `vpn` equals (VSID × 2^16) + (bits 27..12 of the effective address), modulo 2^64, one cycle after the request.
- R2: With `in_seg_1t` = 1 (1 TB segment), `vpn` equals (VSID × 2^28) + (bits 39..12 of the effective address), modulo 2^64, one cycle after the request.
- R3: For a 256 MB segment and page shift p ≥ 12, `hash_pri` equals (VPN >> 16) XOR ((VPN mod 2^16) >> (p − 12)), two cycles after the request.
- R4: For a 1 TB segment and page shift p ≥ 12, with s = VPN >> 28, `hash_pri` equals s XOR (s << 25) XOR ((VPN mod 2^28) >> (p − 12)), two cycles after the request.
- R5: `hash_pri` holds only the low 39 bits of the fold. Higher bits, such as those produced by the shifted segment copy, are discarded.
- R6: When the page shift is valid, `hash_sec` equals the bitwise complement of `hash_pri` within 39 bits.
- R7: A page shift below 12 raises `hash_err` together with `hash_valid`, and both `hash_pri` and `hash_sec` are zero for that request. A page shift of 12 or more leaves `hash_err` low.
- R8: `vpn_valid` follows `in_valid` by one cycle and `hash_valid` follows it by two cycles. Back-to-back requests produce back-to-back results.
- R9: A synchronous active-low reset clears both valid flags and all output data to zero at the next clock edge.
- R10: A cycle without a request leaves `vpn`, `hash_pri`, `hash_sec` and `hash_err` at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_ea | input | 64 | Effective address |
| in_vsid | input | 48 | Virtual segment identifier |
| in_seg_1t | input | 1 | Segment size: 0 = 256 MB, 1 = 1 TB |
| in_pshift | input | 6 | log2 of page size in bytes |
| vpn_valid | output | 1 | `vpn` carries a new result |
| vpn | output | 64 | Virtual page number (address >> 12) |
| hash_valid | output | 1 | Hash outputs carry a new result |
| hash_pri | output | 39 | Primary group hash |
| hash_sec | output | 39 | Secondary group hash |
| hash_err | output | 1 | Page shift below the 4 KB base |

## Verification
The bench sweeps every page shift from 0 to 63 under both segment sizes, across several address and VSID patterns. The patterns include all-ones values, so the shifted segment copy spills past bit 38. A design that used the 256 MB fold for 1 TB segments, or that forgot the shifted copy, fails every large-segment hash. A design that omitted the final 39-bit mask shows stray high bits only under the all-ones patterns. The error-flag boundary is checked at page shifts 11 and 12, and large shifts are exercised where the page-index term drops out entirely. Idle bubbles between requests expose a pipeline that reloads its data registers without a request. A reset issued while the pipeline is full exposes a stage that keeps a stale valid flag.

// File: rtl/hpt_hash_pkg.sv
// Shared constants and types for the page-table index hash.
// Assumes virtual addresses are carried with their low PG_BASE bits dropped.
package hpt_hash_pkg;
    localparam int unsigned PG_BASE         = 12;  // base page shift (4 KB)
    localparam int unsigned SEG_SMALL_SHIFT = 28;  // 256 MB segment
    localparam int unsigned SEG_LARGE_SHIFT = 40;  // 1 TB segment
    localparam int unsigned LARGE_MIX_SHIFT = 25;  // shifted segment copy
    localparam int unsigned HASH_BITS       = 39;  // kept hash width

    typedef enum logic {
        SEG_256M = 1'b0,
        SEG_1T   = 1'b1
    } seg_size_e;
endpackage

// File: rtl/hpt_vpn_stage.sv
// Stage one: forms the virtual page number from the VSID and the effective
// address, picking the in-segment page index width from the segment size.
// Assumes VPN_W is at least the effective address width minus PG_BASE.
module hpt_vpn_stage
    import hpt_hash_pkg::*;
#(
    parameter int unsigned EA_W     = 64,
    parameter int unsigned VSID_W   = 48,
    parameter int unsigned VPN_W    = 64,
    parameter int unsigned PSHIFT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [EA_W-1:0]     in_ea,
    input  logic [VSID_W-1:0]   in_vsid,
    input  seg_size_e           in_seg,
    input  logic [PSHIFT_W-1:0] in_pshift,
    output logic                out_valid,
    output logic [VPN_W-1:0]    out_vpn,
    output seg_size_e           out_seg,
    output logic [PSHIFT_W-1:0] out_pshift,
    output logic                out_err
);
    localparam int unsigned SMALL_IDX = SEG_SMALL_SHIFT - PG_BASE;
    localparam int unsigned LARGE_IDX = SEG_LARGE_SHIFT - PG_BASE;

    logic [VPN_W-1:0] idx_mask;
    logic [VPN_W-1:0] vsid_part;
    logic [VPN_W-1:0] page_part;
    logic [VPN_W-1:0] vpn_next;
    logic             err_next;

    // Build the VPN and the page-shift range check for the incoming request.
    always_comb begin
        if (in_seg == SEG_1T) begin
            idx_mask  = (VPN_W'(1) << LARGE_IDX) - VPN_W'(1);
            vsid_part = VPN_W'(in_vsid) << LARGE_IDX;
        end else begin
            idx_mask  = (VPN_W'(1) << SMALL_IDX) - VPN_W'(1);
            vsid_part = VPN_W'(in_vsid) << SMALL_IDX;
        end
        page_part = VPN_W'(in_ea >> PG_BASE) & idx_mask;
        vpn_next  = vsid_part | page_part;
        err_next  = (in_pshift < PSHIFT_W'(PG_BASE));
    end

    // Register the stage; data loads only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_vpn    <= '0;
            out_seg    <= SEG_256M;
            out_pshift <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vpn    <= vpn_next;
                out_seg    <= in_seg;
                out_pshift <= in_pshift;
                out_err    <= err_next;
            end
        end
    end
endmodule

// File: rtl/hpt_seg_fold.sv
// Folds a VPN into a hash for one segment size: the segment identifier above
// IDX_BITS, optionally mixed with a left-shifted copy of itself, XORed with the
// in-segment page index shifted right by the page-size excess.
// Assumes shamt is the page shift minus the base shift (already range-checked).
module hpt_seg_fold #(
    parameter int unsigned VPN_W     = 64,
    parameter int unsigned HASH_W    = 39,
    parameter int unsigned IDX_BITS  = 16,
    parameter int unsigned MIX_SHIFT = 0,
    parameter int unsigned PSHIFT_W  = 6
) (
    input  logic [VPN_W-1:0]    vpn,
    input  logic [PSHIFT_W-1:0] shamt,
    output logic [HASH_W-1:0]   fold
);
    localparam logic [VPN_W-1:0] IDX_MASK = (VPN_W'(1) << IDX_BITS) - VPN_W'(1);

    logic [VPN_W-1:0] seg_id;
    logic [VPN_W-1:0] seg_mixed;
    logic [VPN_W-1:0] page_term;
    logic [VPN_W-1:0] full;

    assign seg_id = vpn >> IDX_BITS;

    // The mixing term exists only for variants that ask for it.
    generate
        if (MIX_SHIFT > 0) begin : g_mix
            assign seg_mixed = seg_id ^ (seg_id << MIX_SHIFT);
        end else begin : g_plain
            assign seg_mixed = seg_id;
        end
    endgenerate

    // Combine the segment term with the page-index term.
    always_comb begin
        page_term = (vpn & IDX_MASK) >> shamt;
        full      = seg_mixed ^ page_term;
        fold      = full[HASH_W-1:0];
    end
endmodule

// File: rtl/hpt_hash_stage.sv
// Stage two: evaluates both segment-size folds, selects one by the segment
// size of the request and registers primary and secondary hashes.
// Assumes the error flag from stage one marks page shifts below the base.
module hpt_hash_stage
    import hpt_hash_pkg::*;
#(
    parameter int unsigned VPN_W    = 64,
    parameter int unsigned HASH_W   = HASH_BITS,
    parameter int unsigned PSHIFT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [VPN_W-1:0]    in_vpn,
    input  seg_size_e           in_seg,
    input  logic [PSHIFT_W-1:0] in_pshift,
    input  logic                in_err,
    output logic                out_valid,
    output logic [HASH_W-1:0]   out_pri,
    output logic [HASH_W-1:0]   out_sec,
    output logic                out_err
);
    localparam int unsigned N_VAR = 2;

    logic [PSHIFT_W-1:0] shamt;
    logic [HASH_W-1:0]   fold_out [N_VAR];
    logic [HASH_W-1:0]   pick;

    assign shamt = in_pshift - PSHIFT_W'(PG_BASE);

    // One fold per segment size: index 0 = 256 MB, index 1 = 1 TB.
    for (genvar g = 0; g < N_VAR; g++) begin : g_fold
        localparam int unsigned IDX_B = (g == 1) ? (SEG_LARGE_SHIFT - PG_BASE)
                                                 : (SEG_SMALL_SHIFT - PG_BASE);
        localparam int unsigned MIX_B = (g == 1) ? LARGE_MIX_SHIFT : 0;
        hpt_seg_fold #(
            .VPN_W    (VPN_W),
            .HASH_W   (HASH_W),
            .IDX_BITS (IDX_B),
            .MIX_SHIFT(MIX_B),
            .PSHIFT_W (PSHIFT_W)
        ) u_fold (
            .vpn  (in_vpn),
            .shamt(shamt),
            .fold (fold_out[g])
        );
    end

    // Select the fold matching the request's segment size.
    always_comb begin
        pick = (in_seg == SEG_1T) ? fold_out[1] : fold_out[0];
    end

    // Register the hashes; an out-of-range page shift yields zero hashes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pri   <= '0;
            out_sec   <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err <= in_err;
                out_pri <= in_err ? '0 : pick;
                out_sec <= in_err ? '0 : ~pick;
            end
        end
    end
endmodule

// File: rtl/hpt_index_hash.sv
// Top of the page-table index hash: a two-stage pipeline, VPN formation
// followed by the segment-size dependent fold. One request per cycle.
// Assumes in_seg_1t selects 1 TB segments when high.
module hpt_index_hash
    import hpt_hash_pkg::*;
#(
    parameter int unsigned EA_W     = 64,
    parameter int unsigned VSID_W   = 48,
    parameter int unsigned VPN_W    = 64,
    parameter int unsigned PSHIFT_W = 6,
    parameter int unsigned HASH_W   = HASH_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [EA_W-1:0]     in_ea,
    input  logic [VSID_W-1:0]   in_vsid,
    input  logic                in_seg_1t,
    input  logic [PSHIFT_W-1:0] in_pshift,
    output logic                vpn_valid,
    output logic [VPN_W-1:0]    vpn,
    output logic                hash_valid,
    output logic [HASH_W-1:0]   hash_pri,
    output logic [HASH_W-1:0]   hash_sec,
    output logic                hash_err
);
    seg_size_e           s1_seg;
    logic [PSHIFT_W-1:0] s1_pshift;
    logic                s1_err;

    hpt_vpn_stage #(
        .EA_W    (EA_W),
        .VSID_W  (VSID_W),
        .VPN_W   (VPN_W),
        .PSHIFT_W(PSHIFT_W)
    ) u_vpn (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ea     (in_ea),
        .in_vsid   (in_vsid),
        .in_seg    (seg_size_e'(in_seg_1t)),
        .in_pshift (in_pshift),
        .out_valid (vpn_valid),
        .out_vpn   (vpn),
        .out_seg   (s1_seg),
        .out_pshift(s1_pshift),
        .out_err   (s1_err)
    );

    hpt_hash_stage #(
        .VPN_W   (VPN_W),
        .HASH_W  (HASH_W),
        .PSHIFT_W(PSHIFT_W)
    ) u_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (vpn_valid),
        .in_vpn   (vpn),
        .in_seg   (s1_seg),
        .in_pshift(s1_pshift),
        .in_err   (s1_err),
        .out_valid(hash_valid),
        .out_pri  (hash_pri),
        .out_sec  (hash_sec),
        .out_err  (hash_err)
    );
endmodule

// File: rtl/hpt_index_hash_chk.sv
// Property checker for hpt_index_hash, attached by bind below.
// Assumes EA_W >= 40 so the large-segment page index is present.
module hpt_index_hash_chk #(
    parameter int unsigned EA_W     = 64,
    parameter int unsigned VPN_W    = 64,
    parameter int unsigned PSHIFT_W = 6,
    parameter int unsigned HASH_W   = 39
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [EA_W-1:0]     in_ea,
    input logic                in_seg_1t,
    input logic [PSHIFT_W-1:0] in_pshift,
    input logic                vpn_valid,
    input logic [VPN_W-1:0]    vpn,
    input logic                hash_valid,
    input logic [HASH_W-1:0]   hash_pri,
    input logic [HASH_W-1:0]   hash_sec,
    input logic                hash_err
);
    a_r8_vpn_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> vpn_valid);
    a_r8_hash_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vpn_valid |=> hash_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !vpn_valid |=> !hash_valid);
    a_r1_small_index: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_seg_1t) |=> (vpn[15:0] == $past(in_ea[27:12])));
    a_r2_large_index: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_seg_1t) |=> (vpn[27:0] == $past(in_ea[39:12])));
    a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && !hash_err) |-> (hash_sec == ~hash_pri));
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && hash_err) |-> (hash_pri == '0 && hash_sec == '0));
    a_r7_err_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pshift < PSHIFT_W'(12)) |=> ##1 (hash_valid && hash_err));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vpn_valid |=> $stable(hash_pri));
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!vpn_valid && !hash_valid));
endmodule

bind hpt_index_hash hpt_index_hash_chk #(
    .EA_W    (EA_W),
    .VPN_W   (VPN_W),
    .PSHIFT_W(PSHIFT_W),
    .HASH_W  (HASH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ea     (in_ea),
    .in_seg_1t (in_seg_1t),
    .in_pshift (in_pshift),
    .vpn_valid (vpn_valid),
    .vpn       (vpn),
    .hash_valid(hash_valid),
    .hash_pri  (hash_pri),
    .hash_sec  (hash_sec),
    .hash_err  (hash_err)
);

// File: tb/test_hpt_index_hash.sv
// Sweep bench: both segment sizes, every page shift, several address patterns,
// idle bubbles, and a reset with the pipeline full. Expected values use
// multiply/divide arithmetic on 64-bit integers.
module test_hpt_index_hash;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_ea = '0;
    logic [47:0] in_vsid = '0;
    logic        in_seg_1t = 1'b0;
    logic [5:0]  in_pshift = '0;
    logic        vpn_valid;
    logic [63:0] vpn;
    logic        hash_valid;
    logic [38:0] hash_pri;
    logic [38:0] hash_sec;
    logic        hash_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hpt_index_hash i_hpt_index_hash (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ea(in_ea),
        .in_vsid(in_vsid), .in_seg_1t(in_seg_1t), .in_pshift(in_pshift),
        .vpn_valid(vpn_valid), .vpn(vpn), .hash_valid(hash_valid),
        .hash_pri(hash_pri), .hash_sec(hash_sec), .hash_err(hash_err)
    );

    // Pending expectations: p1 = due at the VPN stage, p2 = due at the hash stage.
    bit          p1_v = 0, p2_v = 0;
    logic [63:0] p1_vpn = '0;
    bit          p1_seg = 0, p2_seg = 0;
    int          p1_ps = 0;
    logic [38:0] p2_pri = '0, p2_sec = '0;
    bit          p2_err = 0;
    logic [63:0] held_vpn = '0;
    logic [38:0] held_pri = '0, held_sec = '0;
    bit          held_err = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_vpn(input logic [63:0] ea, input logic [47:0] vs, input bit big);
        logic [63:0] span = big ? (64'd1 << 28) : (64'd1 << 16);
        return 64'(vs) * span + (ea / 64'd4096) % span;
    endfunction

    function automatic logic [38:0] ref_hash(input logic [63:0] v, input bit big, input int ps);
        logic [63:0] div = 64'd1 << (ps - 12);
        logic [63:0] s;
        logic [63:0] h;
        if (big) begin
            s = v / (64'd1 << 28);
            h = s ^ (s * (64'd1 << 25)) ^ ((v % (64'd1 << 28)) / div);
        end else begin
            h = (v / (64'd1 << 16)) ^ ((v % (64'd1 << 16)) / div);
        end
        return 39'(h % (64'd1 << 39));
    endfunction

    // Check outputs due now, advance expectations, then drive one request slot.
    task automatic step(input bit v, input logic [63:0] ea, input logic [47:0] vs,
                        input bit big, input int ps);
        string rv = p1_seg ? "R2" : "R1";
        string rh = p2_err ? "R7" : (p2_seg ? "R4" : "R3");
        if (p1_v) begin
            chk("R8 vpn_valid", 64'(vpn_valid), 64'd1);
            chk(rv, vpn, p1_vpn);
            held_vpn = p1_vpn;
        end else begin
            chk("R8 vpn_valid idle", 64'(vpn_valid), 64'd0);
            chk("R10 vpn hold", vpn, held_vpn);
        end
        if (p2_v) begin
            chk("R8 hash_valid", 64'(hash_valid), 64'd1);
            chk("R7 hash_err", 64'(hash_err), 64'(p2_err));
            chk(rh, 64'(hash_pri), 64'(p2_pri));
            chk(p2_err ? "R7 sec" : "R6", 64'(hash_sec), 64'(p2_sec));
            held_pri = p2_pri; held_sec = p2_sec; held_err = p2_err;
        end else begin
            chk("R8 hash_valid idle", 64'(hash_valid), 64'd0);
            chk("R10 hash hold", 64'(hash_pri), 64'(held_pri));
            chk("R10 sec hold", 64'(hash_sec), 64'(held_sec));
            chk("R10 err hold", 64'(hash_err), 64'(held_err));
        end
        p2_v   = p1_v;
        p2_seg = p1_seg;
        p2_err = (p1_ps < 12);
        p2_pri = p2_err ? 39'd0 : ref_hash(p1_vpn, p1_seg, p1_ps);
        p2_sec = p2_err ? 39'd0 : ~p2_pri;
        p1_v = v;
        if (v) begin
            p1_vpn = ref_vpn(ea, vs, big);
            p1_seg = big;
            p1_ps  = ps;
        end
        in_valid  = v;
        in_ea     = ea;
        in_vsid   = vs;
        in_seg_1t = big;
        in_pshift = 6'(ps);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] ea;
        logic [47:0] vs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: state right after reset
        chk("R9 vpn_valid", 64'(vpn_valid), 64'd0);
        chk("R9 hash_valid", 64'(hash_valid), 64'd0);
        chk("R9 vpn", vpn, 64'd0);
        chk("R9 hash_pri", 64'(hash_pri), 64'd0);
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin ea = '1; vs = '1; end                 // R5: spill above bit 38
                1: begin ea = 64'hAAAA_5555_AAAA_5555; vs = 48'h5555_AAAA_5555; end
                2: begin ea = 64'h0000_00FF_F000_0000; vs = 48'h1; end
                default: begin
                    ea = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
                    vs = 48'(ea ^ 64'hC2B2_AE3D_27D4_EB4F);
                end
            endcase
            for (int big = 0; big < 2; big++) begin
                for (int ps = 0; ps < 64; ps++) begin
                    if (ps % 7 == 3) step(1'b0, ~ea, ~vs, 1'b0, 20); // R10 bubble
                    step(1'b1, ea ^ 64'(ps), vs, big[0], ps);
                end
            end
        end
        // Drain the pipeline.
        step(1'b0, '0, '0, 1'b0, 12);
        step(1'b0, '0, '0, 1'b0, 12);
        step(1'b0, '0, '0, 1'b0, 12);
        // R9: reset while requests are in flight.
        in_valid = 1'b1; in_pshift = 6'd16; in_ea = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R9 vpn_valid mid-run", 64'(vpn_valid), 64'd0);
        chk("R9 hash_valid mid-run", 64'(hash_valid), 64'd0);
        chk("R9 vpn mid-run", vpn, 64'd0);
        chk("R9 hash_sec mid-run", 64'(hash_sec), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule